// File: doc/BRIEF.md
# Expansion Slot Interrupt Aggregator

This block gathers the interrupt requests of seven expansion slots into a single summary interrupt for the main interrupt controller. Each slot drives an active-low request line. A slot counts as requesting while its line is held at 0. The lines are synchronised to the block clock. Each slot then passes through its own enable bit, so software can silence one slot without masking the whole summary interrupt.

The enable register is written with set/clear semantics. Bit 7 of the written byte chooses the operation. Bits 6..0 choose the slots it affects. The summary output is a level and is not an edge-captured flag, so a request that arrives while other slots are already pending is never lost. The summary stays high for as long as any enabled slot is requesting.

Alongside the summary, the block presents two outputs. One is the masked pending vector. The other is the number of the highest pending slot, with slot 6 at the top of the priority order.

Top module: `slot_irq_aggregator`

## Requirements
- R1: During and after reset, the enable register is 0, and `irq_out`, `pend_vec` and `slot_idx` are all 0.
- R2: With `reg_sel`=0 (status), `reg_rdata` returns the inverted request lines in bits 6..0 and 0 in bit 7. It follows a change on `req_n` two clock edges later.
- R3: A write with `reg_sel`=1 and `reg_wdata[7]`=1 sets each enable bit whose position is 1 in `reg_wdata[6:0]`. All other enable bits keep their values.
- R4: A write with `reg_sel`=1 and `reg_wdata[7]`=0 clears each enable bit whose position is 1 in `reg_wdata[6:0]`. Writing 0x7F therefore disables every slot.
- R5: `pend_vec` equals the synchronised, inverted request lines ANDed with the enable register, registered once more.
- R6: `irq_out` is 1 exactly when `pend_vec` is non-zero, and it remains 1 for as long as any enabled slot keeps requesting.
- R7: `slot_idx` is the position of the highest set bit of `pend_vec`, searching from bit 6 down to bit 0. It is 0 while `irq_out` is 0.
- R8: Clearing the enable bit of one slot removes only that slot from `pend_vec`. The summary stays high while another enabled slot is requesting.
- R9: With `reg_sel`=1, `reg_rdata` returns the enable register in bits 6..0 and 0 in bit 7.
- R10: A write with `reg_sel`=0 leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 7 | Active-low slot request lines, slot 6 in bit 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = slot status, 1 = slot enable |
| reg_wdata | input | 8 | Write data: bit 7 selects set (1) or clear (0), bits 6..0 select slots |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_out | output | 1 | Level summary interrupt toward the main controller |
| pend_vec | output | 7 | Masked pending slots |
| slot_idx | output | 3 | Highest pending slot number |

## Verification
The bench sweeps all 128 request patterns under several enable masks and predicts the pending vector, the summary and the priority index arithmetically. This catches an encoder that scans upward, which would report the lowest slot instead of the highest, and a mask applied with the wrong polarity. Separate cases test the set/clear writes. A design that wrote the enable register directly, instead of OR-ing or AND-NOT-ing into it, would destroy bits that the write did not select. A write to the status register is also checked, since a design that decoded the select badly would change the enables. Finally, one slot is disabled while others are requesting. An edge-style summary, or a mask applied to the whole summary, would drop the interrupt here.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;

    localparam int SLOT_N = 7;
    localparam int IDX_W  = $clog2(SLOT_N);
    localparam int REG_W  = SLOT_N + 1;

    typedef logic [SLOT_N-1:0] slot_vec_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } prio_t;

    // Later (higher) set bits overwrite earlier ones, so the highest slot wins.
    function automatic prio_t top_slot(slot_vec_t v);
        prio_t r;
        r = '0;
        for (int i = 0; i < SLOT_N; i++) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_req_sync.sv
module slot_req_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] sync_n
);
    logic [W-1:0] chain [STAGES];

    // Idle level of an active-low line is 1, so every stage resets to all ones.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '1;
                    else     chain[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/slot_enable_reg.sv
module slot_enable_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W:0]   wdata,
    output logic [W-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (wr_en) begin
            if (wdata[W]) en <= en | wdata[W-1:0];
            else          en <= en & ~wdata[W-1:0];
        end
    end

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[W]) |=>
        ((en & $past(wdata[W-1:0])) == $past(wdata[W-1:0])) &&
        ((en & ~$past(wdata[W-1:0])) == ($past(en) & ~$past(wdata[W-1:0]))));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[W]) |=>
        ((en & $past(wdata[W-1:0])) == '0) &&
        ((en & ~$past(wdata[W-1:0])) == ($past(en) & ~$past(wdata[W-1:0]))));

    // R10
    hold_en_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en));
endmodule

// File: rtl/slot_prio_enc.sv
module slot_prio_enc
    import slot_irq_pkg::*;
(
    input  slot_vec_t        pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    prio_t p;

    always_comb begin
        p   = top_slot(pend);
        any = p.valid;
        idx = p.valid ? p.idx : '0;
    end

    // R7
    enc_zero_chk: assert property (@(pend) (pend == '0) |-> (idx == '0 && !any));
endmodule

// File: rtl/slot_irq_aggregator.sv
module slot_irq_aggregator
    import slot_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLOT_N-1:0]        req_n,
    input  logic                     reg_wr,
    input  logic                     reg_sel,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     irq_out,
    output logic [SLOT_N-1:0]        pend_vec,
    output logic [IDX_W-1:0]         slot_idx
);
    slot_vec_t        req_sync_n;
    slot_vec_t        req_act;
    slot_vec_t        en_q;
    slot_vec_t        pend_d;
    logic             any_d;
    logic [IDX_W-1:0] idx_d;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_sel);

    slot_req_sync #(.W(SLOT_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (req_n),
        .sync_n  (req_sync_n)
    );

    assign req_act = ~req_sync_n;

    slot_enable_reg #(.W(SLOT_N)) u_en (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr && sel == SEL_ENABLE),
        .wdata (reg_wdata),
        .en    (en_q)
    );

    assign pend_d = req_act & en_q;

    slot_prio_enc u_enc (
        .pend (pend_d),
        .any  (any_d),
        .idx  (idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vec <= '0;
            irq_out  <= 1'b0;
            slot_idx <= '0;
        end else begin
            pend_vec <= pend_d;
            irq_out  <= any_d;
            slot_idx <= idx_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = {1'b0, req_act};
            SEL_ENABLE: reg_rdata = {1'b0, en_q};
            default:    reg_rdata = '0;
        endcase
    end

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pend_vec != '0));

    // R7
    idx_top_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((pend_vec >> slot_idx) == SLOT_N'(1)));

    // R7
    idx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_out |-> (slot_idx == '0));

    // R5
    pend_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & ~$past(en_q)) == '0);

    // R2
    rdata_top_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1] == 1'b0);
endmodule

// File: tb/sim_slot_irq_aggregator.sv
module sim_slot_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] req_n;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_out;
    logic [6:0] pend_vec;
    logic [2:0] slot_idx;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    slot_irq_aggregator u0 (
        .clk(clk), .rst(rst), .req_n(req_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .pend_vec(pend_vec), .slot_idx(slot_idx)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic rd_en(string req, logic [6:0] exp);
        @(negedge clk);
        reg_sel = 1'b1;
        #1;
        check(req, reg_rdata, {1'b0, exp});
    endtask

    function automatic logic [2:0] exp_top(logic [6:0] v);
        for (int i = 6; i >= 0; i--) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic settle_req(logic [6:0] r);
        @(negedge clk);
        req_n = r;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(string tag, logic [6:0] r, logic [6:0] en);
        logic [6:0] p;
        p = ~r & en;
        check({tag, " R5 pend"}, pend_vec, p);
        check({tag, " R6 irq"}, irq_out, p != 0);
        check({tag, " R7 idx"}, slot_idx, exp_top(p));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [6:0] masks [5];
        masks[0] = 7'h7F; masks[1] = 7'h55; masks[2] = 7'h2A;
        masks[3] = 7'h40; masks[4] = 7'h01;

        rst = 1'b1; req_n = 7'h7F; reg_wr = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq_out, 0);
        check("R1 pend", pend_vec, 0);
        check("R1 idx", slot_idx, 0);
        rst = 1'b0;
        rd_en("R1 enable", 7'h00);

        // R3 set only selected bits, cumulatively
        wr_reg(1'b1, 8'h85);
        rd_en("R3 set 05", 7'h05);
        wr_reg(1'b1, 8'hC2);
        rd_en("R3 set 47 / R9 read", 7'h47);
        // R4 clear only selected bits
        wr_reg(1'b1, 8'h01);
        rd_en("R4 clear bit0", 7'h46);
        wr_reg(1'b1, 8'h7F);
        rd_en("R4 clear all", 7'h00);
        // R10 status write ignored
        wr_reg(1'b0, 8'hFF);
        rd_en("R10 status write", 7'h00);

        // R2 status read sweep
        for (int r = 0; r < 128; r += 9) begin
            settle_req(7'(r));
            reg_sel = 1'b0;
            #1;
            check("R2 status", reg_rdata, {1'b0, ~7'(r)});
            reg_sel = 1'b1;
        end

        // R5 R6 R7 exhaustive sweep under several masks
        foreach (masks[m]) begin
            wr_reg(1'b1, 8'h7F);
            wr_reg(1'b1, {1'b1, masks[m]});
            for (int r = 0; r < 128; r++) begin
                settle_req(7'(r));
                check_out("sweep", 7'(r), masks[m]);
            end
        end

        // R8 masking one slot keeps others and the summary alive
        wr_reg(1'b1, 8'hFF);
        settle_req(7'h00);
        check_out("R8 all", 7'h00, 7'h7F);
        wr_reg(1'b1, 8'h40);
        repeat (2) @(negedge clk);
        check("R8 pend after mask", pend_vec, 7'h3F);
        check("R8 irq stays", irq_out, 1);
        check("R8 idx", slot_idx, 5);
        // R6 late request while another pending keeps summary high
        settle_req(7'h7E);
        check("R6 one left", irq_out, 1);
        settle_req(7'h5E);
        check("R6 added", pend_vec, 7'h21);
        check("R7 added idx", slot_idx, 5);
        settle_req(7'h7F);
        check("R6 drop", irq_out, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule